// File: doc/BRIEF.md
# SPI serial clock divider with linear and power-of-two laws

This block derives the serial clock of an SPI shift engine from the module clock. A configuration word holds two divider fields and a law select. The linear law divides the module clock by an even integer. The power-of-two law divides it by a power of two. The shift engine holds `run` high for the length of a burst. While `run` is high, the block emits a one-cycle `sck_tick` strobe at every half-period of the serial clock. It also emits `sck_phase`, a level that toggles on each strobe and so has a 50% duty cycle. The downstream logic applies the idle clock polarity to `sck_phase` and uses `sck_tick` as its shift/sample enable.

The divider value is captured on the first cycle of a burst and held until the burst ends. While `run` is low, the counter and the phase are held cleared. Because of this, every burst starts from the same alignment: the first serial clock edge comes one whole half-period after the start.

Top module: `spi_sck_divider`

## Requirements
- R1: After reset, with `run` low, `sck_tick` and `sck_phase` are both 0.
- R2: When `cfg_word[12]` = 1 (linear law), the half-period is n+1 module clock cycles, where n = `cfg_word[7:0]`. The first `sck_tick` comes n+1 cycles after the first clock edge that samples `run` high. Later strobes follow every n+1 cycles.
- R3: When `cfg_word[12]` = 0 (power-of-two law), the half-period is 2^n module clock cycles, where n = `cfg_word[11:8]`. This holds up to n = 15, which gives a half-period of 32768 cycles.
- R4: The law select is bit 12, with 1 choosing linear and 0 choosing power-of-two. The field that the unselected law would use has no effect on the timing.
- R5: In the linear law with n = 0, `sck_tick` is high on every cycle of the burst. This is the fastest serial clock, half the module clock.
- R6: `sck_phase` starts each burst at 0. It inverts on the clock edge that ends each `sck_tick` cycle and is otherwise steady, so it is high and low for equal numbers of cycles.
- R7: While `run` is low, `sck_tick` stays 0, and `sck_phase` is 0 from the following cycle. A new burst restarts the half-period count from zero.
- R8: A change to `cfg_word` while `run` is high does not change the strobe spacing of that burst. The new value is used from the next burst start.
- R9: If `run` is low in the cycle where a strobe would fall, no strobe is emitted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_word | input | 13 | Divider configuration: linear n [7:0], power-of-two n [11:8], law select [12] |
| run | input | 1 | Burst active, driven by the shift engine |
| sck_tick | output | 1 | One-cycle strobe at each serial clock half-period |
| sck_phase | output | 1 | Serial clock level before polarity, toggles on each strobe |

## Verification
Two events can land in the same cycle. One is the shift engine ending a burst. The other is the counter reaching its half-period limit. The bench sets up this case by dropping `run` partway through a clock cycle, exactly in the cycle where a strobe is due. It then checks that no strobe appears and that the phase is cleared on the next cycle, not inverted. A second overlap is a configuration write landing partway through a burst. The bench judges this case by counting strobe spacing against the old value until the burst ends, and then against the new value after a restart.

// File: rtl/spi_clkdiv_pkg.sv
package spi_clkdiv_pkg;

    // Divider law chosen by the select bit of the configuration word.
    typedef enum logic {
        LAW_POW2   = 1'b0,
        LAW_LINEAR = 1'b1
    } div_law_e;

    // Burst state of the half-period counter.
    typedef enum logic {
        DIV_IDLE = 1'b0,
        DIV_RUN  = 1'b1
    } div_state_e;

    function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/spi_clkdiv_decode.sv
module spi_clkdiv_decode
    import spi_clkdiv_pkg::*;
#(
    parameter int LIN_W = 8,
    parameter int EXP_W = 4,
    parameter int CNT_W = 15
) (
    input  logic [LIN_W+EXP_W:0] cfg,
    output logic [CNT_W-1:0]     half_m1
);
    localparam int CFG_W = LIN_W + EXP_W + 1;

    logic [LIN_W-1:0] lin_n;
    logic [EXP_W-1:0] exp_n;
    div_law_e         law;
    logic [CNT_W:0]   pow_val;

    always_comb begin
        lin_n   = cfg[LIN_W-1:0];
        exp_n   = cfg[LIN_W+EXP_W-1:LIN_W];
        law     = div_law_e'(cfg[CFG_W-1]);
        pow_val = (CNT_W+1)'(1) << exp_n;
        if (law == LAW_LINEAR)
            half_m1 = CNT_W'(lin_n);
        else
            half_m1 = CNT_W'(pow_val - (CNT_W+1)'(1));
    end

endmodule

// File: rtl/spi_clkdiv_counter.sv
module spi_clkdiv_counter
    import spi_clkdiv_pkg::*;
#(
    parameter int CNT_W = 15
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [CNT_W-1:0] half_m1_in,
    output logic             tick
);
    div_state_e       state_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] lim_q;
    logic             at_lim;

    assign at_lim = (cnt_q == lim_q);
    assign tick   = run && (state_q == DIV_RUN) && at_lim;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= DIV_IDLE;
            cnt_q   <= '0;
            lim_q   <= '0;
        end else if (!run) begin
            state_q <= DIV_IDLE;
            cnt_q   <= '0;
        end else if (state_q == DIV_IDLE) begin
            state_q <= DIV_RUN;
            cnt_q   <= '0;
            lim_q   <= half_m1_in;
        end else if (at_lim) begin
            cnt_q   <= '0;
        end else begin
            cnt_q   <= cnt_q + CNT_W'(1);
        end
    end

endmodule

// File: rtl/spi_clkdiv_phase.sv
module spi_clkdiv_phase (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic tick,
    output logic phase
);
    always_ff @(posedge clk) begin
        if (rst || !run)
            phase <= 1'b0;
        else if (tick)
            phase <= ~phase;
    end
endmodule

// File: rtl/spi_sck_divider.sv
module spi_sck_divider
    import spi_clkdiv_pkg::*;
#(
    parameter  int LIN_W = 8,
    parameter  int EXP_W = 4,
    localparam int CFG_W = LIN_W + EXP_W + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CFG_W-1:0] cfg_word,
    input  logic             run,
    output logic             sck_tick,
    output logic             sck_phase
);
    localparam int CNT_W = int'(max_u(LIN_W, (1 << EXP_W) - 1));

    logic [CNT_W-1:0] half_m1;

    spi_clkdiv_decode #(.LIN_W(LIN_W), .EXP_W(EXP_W), .CNT_W(CNT_W)) u_decode (
        .cfg     (cfg_word),
        .half_m1 (half_m1)
    );

    spi_clkdiv_counter #(.CNT_W(CNT_W)) u_counter (
        .clk        (clk),
        .rst        (rst),
        .run        (run),
        .half_m1_in (half_m1),
        .tick       (sck_tick)
    );

    spi_clkdiv_phase u_phase (
        .clk   (clk),
        .rst   (rst),
        .run   (run),
        .tick  (sck_tick),
        .phase (sck_phase)
    );

endmodule

// File: rtl/spi_sck_divider_chk.sv
module spi_sck_divider_chk #(
    parameter int LIN_W = 8,
    parameter int EXP_W = 4
) (
    input logic clk,
    input logic rst,
    input logic run,
    input logic sck_tick,
    input logic sck_phase
);
    localparam int MAX_LIN = 1 << LIN_W;
    localparam int MAX_EXP = 1 << ((1 << EXP_W) - 1);
    localparam int MAX_H   = (MAX_LIN > MAX_EXP) ? MAX_LIN : MAX_EXP;

    int unsigned gap_q;

    always_ff @(posedge clk) begin
        if (rst || !run || sck_tick)
            gap_q <= (run && !rst && !sck_tick) ? 1 : 0;
        else
            gap_q <= gap_q + 1;
    end

    // R2 / R3: the spacing between strobes never exceeds the longest half-period.
    p_gap_bound_r2: assert property (@(posedge clk) disable iff (rst)
        run |-> (gap_q <= MAX_H));

    // R6: the phase inverts after a strobe cycle.
    p_phase_flip_r6: assert property (@(posedge clk) disable iff (rst)
        (sck_tick && run) |=> (sck_phase != $past(sck_phase)));

    // R6: the phase holds steady while the burst continues without a strobe.
    p_phase_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (run && !sck_tick) |=> $stable(sck_phase));

    // R7: the phase is cleared after an idle cycle.
    p_idle_clear_r7: assert property (@(posedge clk) disable iff (rst)
        !run |=> !sck_phase);

    // R7: no strobe in the cycle that follows an idle cycle.
    p_no_early_tick_r7: assert property (@(posedge clk) disable iff (rst)
        !$past(run) |-> !sck_tick);

endmodule

bind spi_sck_divider spi_sck_divider_chk #(.LIN_W(LIN_W), .EXP_W(EXP_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .run       (run),
    .sck_tick  (sck_tick),
    .sck_phase (sck_phase)
);

// File: tb/spi_sck_divider_bench.sv
module spi_sck_divider_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [12:0] cfg_word = '0;
    logic        run = 1'b0;
    logic        sck_tick;
    logic        sck_phase;

    int checks = 0;
    int errors = 0;
    int cyc    = 0;

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    spi_sck_divider u_spi_sck_divider (
        .clk(clk), .rst(rst), .cfg_word(cfg_word), .run(run),
        .sck_tick(sck_tick), .sck_phase(sck_phase)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [12:0] lin_cfg(input int n, input int junk);
        return {1'b1, 4'(junk), 8'(n)};
    endfunction

    function automatic logic [12:0] pow_cfg(input int n, input int junk);
        return {1'b0, 4'(n), 8'(junk)};
    endfunction

    // Start a burst and check strobes/phase for a number of half-periods.
    // Optional reconfiguration at cycle chg_at (0 = none).
    task automatic burst(input logic [12:0] cfg, input int half, input int halves,
                         input string req, input int chg_at, input logic [12:0] new_cfg);
        int bad_t = 0, bad_p = 0, first_k = 0, act_t = 0, act_p = 0;
        @(negedge clk);
        cfg_word = cfg;
        run = 1'b1;
        for (int k = 1; k <= half * halves; k++) begin
            @(negedge clk);
            if ((sck_tick !== ((k % half) == 0)) && bad_t == 0) begin
                first_k = k; act_t = sck_tick;
            end
            if (sck_tick !== ((k % half) == 0)) bad_t++;
            if (sck_phase !== 1'(((k - 1) / half) % 2)) begin
                if (bad_p == 0) act_p = k;
                bad_p++;
            end
            if (chg_at != 0 && k == chg_at) cfg_word = new_cfg;
        end
        check(bad_t == 0, {req, " tick spacing"}, first_k, 0);
        check(bad_p == 0, {req, " phase duty (R6)"}, act_p, 0);
    endtask

    task automatic stop_and_check(input string req);
        @(negedge clk);
        run = 1'b0;
        #1 check(sck_tick == 1'b0, {req, " no tick while idle (R7)"}, sck_tick, 0);
        @(negedge clk);
        check(sck_phase == 1'b0, {req, " phase cleared idle (R7)"}, sck_phase, 0);
    endtask

    task automatic t_reset;
        repeat (3) @(negedge clk);
        check(sck_tick == 1'b0 && sck_phase == 1'b0, "R1 reset outputs", {sck_tick, sck_phase}, 0);
        rst = 1'b0;
        @(negedge clk);
        check(sck_tick == 1'b0 && sck_phase == 1'b0, "R1 after reset", {sck_tick, sck_phase}, 0);
    endtask

    task automatic t_linear;
        burst(lin_cfg(3, 9), 4, 6, "R2 R4 linear n=3", 0, '0);
        stop_and_check("R2");
        burst(lin_cfg(0, 15), 1, 8, "R5 linear n=0", 0, '0);
        stop_and_check("R5");
        burst(lin_cfg(255, 0), 256, 4, "R2 linear n=255", 0, '0);
        stop_and_check("R2");
    endtask

    task automatic t_pow2;
        burst(pow_cfg(0, 200), 1, 6, "R3 R4 pow2 n=0", 0, '0);
        stop_and_check("R3");
        burst(pow_cfg(3, 77), 8, 6, "R3 pow2 n=3", 0, '0);
        stop_and_check("R3");
        burst(pow_cfg(15, 1), 32768, 2, "R3 pow2 n=15", 0, '0);
        stop_and_check("R3");
    endtask

    task automatic t_idle;
        int seen = 0;
        @(negedge clk);
        cfg_word = lin_cfg(0, 0);
        run = 1'b0;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            if (sck_tick || sck_phase) seen++;
        end
        check(seen == 0, "R7 idle with fastest config", seen, 0);
        burst(lin_cfg(2, 0), 3, 4, "R7 restart alignment", 0, '0);
        stop_and_check("R7");
    endtask

    task automatic t_cfg_change;
        burst(lin_cfg(4, 0), 5, 5, "R8 mid-burst change ignored", 7, lin_cfg(1, 0));
        stop_and_check("R8");
        burst(lin_cfg(1, 0), 2, 4, "R8 new value at next start", 0, '0);
        stop_and_check("R8");
    endtask

    task automatic t_drop_on_tick;
        @(negedge clk);
        cfg_word = lin_cfg(2, 0);
        run = 1'b1;
        @(negedge clk);
        @(negedge clk);
        @(negedge clk);
        run = 1'b0;
        #1 check(sck_tick == 1'b0, "R9 no tick when run drops", sck_tick, 0);
        @(negedge clk);
        check(sck_phase == 1'b0, "R9 phase not toggled", sck_phase, 0);
    endtask

    initial begin
        t_reset();
        t_linear();
        t_pow2();
        t_idle();
        t_cfg_change();
        t_drop_on_tick();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        wait (cyc >= 190000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 190000);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule